// File: doc/BRIEF.md
# Parallel Panel Write Sequencer

This block drives one write at a time onto an 8080-style parallel display bus. An upstream source offers a word with a valid/ready handshake. Each word comes with a flag that tells whether the word is a command or pixel/parameter data. Once the block accepts a word, it walks the bus through four phases and then releases it:

1. Select setup: the register-select line is valid and chip select is still high.
2. Strobe setup: chip select is low and the write strobe is high.
3. Strobe: the write strobe is low and the data bus carries the word.
4. Hold: the strobe is high again, while chip select and data are held.

Four run-time configuration inputs set the phase lengths, one per phase. Each phase lasts the configured value plus one clock.

The configuration inputs are static. They are sampled only when a word is accepted, so software can change them between transfers without tearing the current one. A typical setting is select setup 0, strobe setup 0, strobe 1 and hold 0. With that setting a write takes five clocks from acceptance to release of chip select. A field 4 bits wide gives each phase a length from 1 to 16 clocks.

Top module: `pbus_write_seq`

## Requirements
- R1: During and right after reset, bus_cs_n and bus_wr_n are 1, bus_data is 0, busy is 0 and in_ready is 1.
- R2: On the clock edge that accepts a word (in_valid and in_ready both 1), bus_sel takes the value of in_sel (1 = data, 0 = command). bus_cs_n first reads 0 exactly cfg_cs_setup+1 clocks after that edge.
- R3: bus_wr_n first reads 0 exactly cfg_wr_setup+1 clocks after bus_cs_n went low.
- R4: bus_wr_n stays 0 for exactly cfg_wr_active+1 clocks.
- R5: bus_cs_n returns to 1 exactly cfg_wr_hold+1 clocks after bus_wr_n returned to 1.
- R6: bus_data equals the accepted word from the clock where bus_wr_n falls until chip select is released, and is 0 at all other times. bus_sel and bus_data hold steady through a transfer.
- R7: busy is 1 and in_ready is 0 from the accepting edge until the edge that raises bus_cs_n. A word offered while busy is ignored: it alters neither the transfer in flight nor the bus afterwards.
- R8: The four timing inputs are sampled on the accepting edge. Changing them during a transfer does not change that transfer's phase lengths.
- R9: bus_wr_n is low only while bus_cs_n is low. Between back-to-back transfers bus_cs_n is high for at least one clock.
- R10: Every timing field is 4 bits. Value 0 gives a 1-clock phase and value 15 gives a 16-clock phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all phases are counted in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream word is offered |
| in_ready | output | 1 | Block can accept a word |
| in_sel | input | 1 | Register-select value for the word: 1 data, 0 command |
| in_data | input | DW (16) | Word to write |
| cfg_cs_setup | input | TW (4) | Select setup length minus one |
| cfg_wr_setup | input | TW (4) | Strobe setup length minus one |
| cfg_wr_active | input | TW (4) | Strobe low length minus one |
| cfg_wr_hold | input | TW (4) | Hold length minus one |
| bus_sel | output | 1 | Register-select line to the panel |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_data | output | DW (16) | Parallel data bus |
| busy | output | 1 | A transfer is in progress |

## Verification
The sequence is run with four timing settings:
- The typical setting.
- An uneven mix (2, 3, 1, 4). Because every phase has a different length, swapping two counters would shift the measured edges and be caught.
- All zeros, where every phase is a single clock.
- All fifteens, where every phase is sixteen clocks.

Further runs cover other cases. One changes the timing inputs mid-transfer, which separates sampling at acceptance from live use. Another offers a second word while busy, which shows whether a stray handshake leaks into the bus. A last run streams two words with no idle gap, to check that chip select still rises between them.

// File: rtl/pbw_pkg.sv
package pbw_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SELSU  = 3'd1,
    PH_WRSU   = 3'd2,
    PH_STROBE = 3'd3,
    PH_HOLD   = 3'd4
  } pbw_phase_t;

  function automatic logic phase_selects(input pbw_phase_t ph);
    return (ph == PH_WRSU) || (ph == PH_STROBE) || (ph == PH_HOLD);
  endfunction

  function automatic logic phase_drives(input pbw_phase_t ph);
    return (ph == PH_STROBE) || (ph == PH_HOLD);
  endfunction

endpackage

// File: rtl/pbw_cfg_latch.sv
module pbw_cfg_latch #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] wr_setup_in,
  input  logic [TW-1:0] wr_active_in,
  input  logic [TW-1:0] wr_hold_in,
  output logic [TW-1:0] wr_setup_q,
  output logic [TW-1:0] wr_active_q,
  output logic [TW-1:0] wr_hold_q
);

  localparam logic [TW-1:0] ACTIVE_RST = TW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_setup_q  <= '0;
      wr_active_q <= ACTIVE_RST;
      wr_hold_q   <= '0;
    end else if (load) begin
      wr_setup_q  <= wr_setup_in;
      wr_active_q <= wr_active_in;
      wr_hold_q   <= wr_hold_in;
    end
  end

endmodule

// File: rtl/pbw_phase_ctr.sv
module pbw_phase_ctr #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - TW'(1);
    end
  end

  assign expired = (remain_q == '0);

endmodule

// File: rtl/pbw_seq_fsm.sv
module pbw_seq_fsm
  import pbw_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          expired,
  input  logic [TW-1:0] cs_setup_in,
  input  logic [TW-1:0] wr_setup_q,
  input  logic [TW-1:0] wr_active_q,
  input  logic [TW-1:0] wr_hold_q,
  output pbw_phase_t    phase_nxt,
  output logic          ctr_load,
  output logic [TW-1:0] ctr_val
);

  pbw_phase_t phase_q;

  always_comb begin
    phase_nxt = phase_q;
    ctr_load  = 1'b0;
    ctr_val   = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          phase_nxt = PH_SELSU;
          ctr_load  = 1'b1;
          ctr_val   = cs_setup_in;
        end
      end
      PH_SELSU: begin
        if (expired) begin
          phase_nxt = PH_WRSU;
          ctr_load  = 1'b1;
          ctr_val   = wr_setup_q;
        end
      end
      PH_WRSU: begin
        if (expired) begin
          phase_nxt = PH_STROBE;
          ctr_load  = 1'b1;
          ctr_val   = wr_active_q;
        end
      end
      PH_STROBE: begin
        if (expired) begin
          phase_nxt = PH_HOLD;
          ctr_load  = 1'b1;
          ctr_val   = wr_hold_q;
        end
      end
      PH_HOLD: begin
        if (expired) phase_nxt = PH_IDLE;
      end
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_nxt;
  end

endmodule

// File: rtl/pbw_pins.sv
module pbw_pins
  import pbw_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          sel_in,
  input  logic [DW-1:0] data_in,
  input  pbw_phase_t    phase_nxt,
  output logic          sel_q,
  output logic          cs_n_q,
  output logic          wr_n_q,
  output logic [DW-1:0] data_q,
  output logic          busy_q
);

  logic [DW-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      sel_q  <= 1'b0;
    end else if (accept) begin
      word_q <= data_in;
      sel_q  <= sel_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_q <= 1'b1;
      wr_n_q <= 1'b1;
      data_q <= '0;
      busy_q <= 1'b0;
    end else begin
      cs_n_q <= !phase_selects(phase_nxt);
      wr_n_q <= (phase_nxt != PH_STROBE);
      data_q <= phase_drives(phase_nxt) ? word_q : '0;
      busy_q <= (phase_nxt != PH_IDLE);
    end
  end

endmodule

// File: rtl/pbus_write_seq.sv
module pbus_write_seq
  import pbw_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_sel,
  input  logic [DW-1:0] in_data,
  input  logic [TW-1:0] cfg_cs_setup,
  input  logic [TW-1:0] cfg_wr_setup,
  input  logic [TW-1:0] cfg_wr_active,
  input  logic [TW-1:0] cfg_wr_hold,
  output logic          bus_sel,
  output logic          bus_cs_n,
  output logic          bus_wr_n,
  output logic [DW-1:0] bus_data,
  output logic          busy
);

  logic          accept;
  logic          expired;
  logic          ctr_load;
  logic [TW-1:0] ctr_val;
  logic [TW-1:0] ws_q, wa_q, wh_q;
  pbw_phase_t    phase_nxt;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  pbw_cfg_latch #(.TW(TW)) u_cfg (
    .clk          (clk),
    .rst          (rst),
    .load         (accept),
    .wr_setup_in  (cfg_wr_setup),
    .wr_active_in (cfg_wr_active),
    .wr_hold_in   (cfg_wr_hold),
    .wr_setup_q   (ws_q),
    .wr_active_q  (wa_q),
    .wr_hold_q    (wh_q)
  );

  pbw_phase_ctr #(.TW(TW)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (ctr_load),
    .load_val (ctr_val),
    .expired  (expired)
  );

  pbw_seq_fsm #(.TW(TW)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .expired     (expired),
    .cs_setup_in (cfg_cs_setup),
    .wr_setup_q  (ws_q),
    .wr_active_q (wa_q),
    .wr_hold_q   (wh_q),
    .phase_nxt   (phase_nxt),
    .ctr_load    (ctr_load),
    .ctr_val     (ctr_val)
  );

  pbw_pins #(.DW(DW)) u_pins (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .sel_in    (in_sel),
    .data_in   (in_data),
    .phase_nxt (phase_nxt),
    .sel_q     (bus_sel),
    .cs_n_q    (bus_cs_n),
    .wr_n_q    (bus_wr_n),
    .data_q    (bus_data),
    .busy_q    (busy)
  );

endmodule

// File: rtl/pbw_checker.sv
module pbw_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          bus_sel,
  input logic          bus_cs_n,
  input logic          bus_wr_n,
  input logic [DW-1:0] bus_data,
  input logic          busy
);

  a_r9_strobe_inside_select: assert property (@(posedge clk) disable iff (rst)
    !bus_wr_n |-> !bus_cs_n);

  a_r7_accept_sets_busy: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (busy && !in_ready && bus_cs_n));

  a_r7_release_frees: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_cs_n) |-> (!busy && in_ready));

  a_r5_strobe_up_before_release: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_cs_n) |-> $past(bus_wr_n));

  a_r6_data_steady_in_strobe: assert property (@(posedge clk) disable iff (rst)
    (!bus_wr_n && $past(!bus_wr_n)) |-> $stable(bus_data));

  a_r6_sel_steady_in_transfer: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(bus_sel));

  a_r6_data_quiet_unselected: assert property (@(posedge clk) disable iff (rst)
    bus_cs_n |-> (bus_data == '0));

endmodule

bind pbus_write_seq pbw_checker #(.DW(DW)) u_pbw_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .bus_sel  (bus_sel),
  .bus_cs_n (bus_cs_n),
  .bus_wr_n (bus_wr_n),
  .bus_data (bus_data),
  .busy     (busy)
);

// File: tb/test_pbus_write_seq.sv
`timescale 1ns/1ps
module test_pbus_write_seq;
  localparam int DW = 16;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_sel = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [TW-1:0] cfg_cs_setup = '0, cfg_wr_setup = '0, cfg_wr_active = 4'd1, cfg_wr_hold = '0;
  logic in_ready, bus_sel, bus_cs_n, bus_wr_n, busy;
  logic [DW-1:0] bus_data;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pbus_write_seq #(.DW(DW), .TW(TW)) i_pbus_write_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sel(in_sel), .in_data(in_data),
    .cfg_cs_setup(cfg_cs_setup), .cfg_wr_setup(cfg_wr_setup),
    .cfg_wr_active(cfg_wr_active), .cfg_wr_hold(cfg_wr_hold),
    .bus_sel(bus_sel), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
    .bus_data(bus_data), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // mode: 0 plain, 1 change timing mid-transfer (R8), 2 offer word while busy (R7)
  task automatic xfer(input int cs, input int ws, input int wa, input int wh,
                      input bit sel, input logic [DW-1:0] d, input int mode, input string sc);
    int e_csl, e_wrl, e_wrh, e_csh;
    int m_csl, m_wrl, m_wrh, m_csh;
    int bad_data, bad_sel, bad_busy;
    e_csl = cs + 1;
    e_wrl = e_csl + ws + 1;
    e_wrh = e_wrl + wa + 1;
    e_csh = e_wrh + wh + 1;
    m_csl = -1; m_wrl = -1; m_wrh = -1; m_csh = -1;
    bad_data = 0; bad_sel = 0; bad_busy = 0;
    while (!in_ready) @(negedge clk);
    cfg_cs_setup = TW'(cs); cfg_wr_setup = TW'(ws);
    cfg_wr_active = TW'(wa); cfg_wr_hold = TW'(wh);
    in_sel = sel; in_data = d; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(bus_cs_n == 1'b1, {sc, " R9 select high right after accept"}, int'(bus_cs_n), 1);
    for (int k = 0; k < 300; k++) begin
      if (k > 0) @(negedge clk);
      if (mode == 1 && k == 1) begin
        cfg_cs_setup = 4'd9; cfg_wr_setup = 4'd11;
        cfg_wr_active = 4'd13; cfg_wr_hold = 4'd7;
      end
      if (mode == 2 && k == 1) begin
        in_valid = 1'b1; in_sel = !sel; in_data = ~d;
      end
      if (mode == 2 && k == 3) in_valid = 1'b0;
      if (m_csl < 0 && !bus_cs_n) m_csl = k;
      if (m_wrl < 0 && !bus_wr_n) m_wrl = k;
      if (m_wrl >= 0 && m_wrh < 0 && bus_wr_n) m_wrh = k;
      if (m_csl >= 0 && m_csh < 0 && bus_cs_n) m_csh = k;
      if (bus_data !== ((k >= e_wrl && k < e_csh) ? d : '0)) bad_data++;
      if (bus_sel !== sel) bad_sel++;
      if (busy !== (k < e_csh) || in_ready !== !(k < e_csh)) bad_busy++;
      if (m_csh >= 0) break;
    end
    chk(m_csl == e_csl, {sc, " R2 select fall after accept"}, m_csl, e_csl);
    chk(m_wrl - m_csl == ws + 1, {sc, " R3 strobe setup"}, m_wrl - m_csl, ws + 1);
    chk(m_wrh - m_wrl == wa + 1, {sc, " R4 strobe width"}, m_wrh - m_wrl, wa + 1);
    chk(m_csh - m_wrh == wh + 1, {sc, " R5 hold"}, m_csh - m_wrh, wh + 1);
    chk(bad_data == 0, {sc, " R6 data bus mismatches"}, bad_data, 0);
    chk(bad_sel == 0, {sc, " R6 select line mismatches"}, bad_sel, 0);
    chk(bad_busy == 0, {sc, " R7 busy/ready mismatches"}, bad_busy, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(bus_cs_n == 1'b1, "R1 cs_n in reset", int'(bus_cs_n), 1);
    chk(bus_wr_n == 1'b1, "R1 wr_n in reset", int'(bus_wr_n), 1);
    chk(bus_data == '0, "R1 data in reset", int'(bus_data), 0);
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_defaults(); xfer(0, 0, 1, 0, 1'b0, 16'h002C, 0, "defaults"); endtask
  task automatic t_mixed();    xfer(2, 3, 1, 4, 1'b1, 16'hA5C3, 0, "mixed");    endtask
  task automatic t_min();      xfer(0, 0, 0, 0, 1'b1, 16'h0001, 0, "R10 min");  endtask
  task automatic t_max();      xfer(15, 15, 15, 15, 1'b0, 16'hFFFF, 0, "R10 max"); endtask
  task automatic t_midchange(); xfer(1, 2, 0, 1, 1'b1, 16'h3C3C, 1, "R8 midchange"); endtask

  task automatic t_ignore();
    xfer(3, 1, 2, 1, 1'b1, 16'h1234, 2, "R7 ignore");
    @(negedge clk);
    chk(busy == 1'b0, "R7 stray word did not start a transfer", int'(busy), 0);
    chk(bus_cs_n == 1'b1, "R7 bus stays released", int'(bus_cs_n), 1);
  endtask

  task automatic t_b2b();
    xfer(0, 1, 0, 0, 1'b0, 16'h00AA, 0, "R9 b2b first");
    xfer(0, 0, 2, 1, 1'b1, 16'h5500, 0, "R9 b2b second");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_defaults();
    t_mixed();
    t_min();
    t_max();
    t_midchange();
    t_ignore();
    t_b2b();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule